// File: doc/BRIEF.md
# Vectored Interrupt Polling Controller

This block arbitrates interrupt requests for a small 8-bit processor core. On each machine-cycle strobe it looks at the request flags of up to sixteen sources, masked by per-source enables and a global enable. When the core reports that it can accept an interrupt, the block picks one source, raises a one-cycle call request and presents that source's vector address. No request is stored between polls: a flag counts only if it is active at the poll where acceptance is possible.

When the call is issued, the block also strobes clear pulses for sources whose flags are cleared by hardware. Timer overflow flags are always cleared. External-pin flags are cleared only in edge mode. Every other flag is left for software. Two priority levels are supported. An in-service record per level blocks requests of equal or lower level until the core reports a return-from-interrupt. A plain subroutine return does not affect this record. The call request asks only for the program counter to be saved. No status-word save is requested.

Top module: `irq_poll_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, call_req, flag_clr and svc_level are all zero.
- R2: A poll accepted at a clock edge gives call_req high for the next cycle. In that same cycle vec_addr equals 16'h0003 + 8·index of the chosen source (index 0 → 0003h, index 15 → 007Bh).
- R3: A poll is accepted only at an edge where cyc_stb, cpu_ready and glb_en are all 1 and reti_stb is 0. At any other edge no call is made.
- R4: Only sources whose irq_flag and irq_en are both 1 at the accepting edge are eligible. A flag that was active at an earlier, refused poll is never serviced later on the strength of that earlier state.
- R5: Eligible sources with irq_hi = 1 take precedence over those with irq_hi = 0. Within a level, the lowest index wins.
- R6: When timer sources (index 1 and index 3) are chosen, the matching flag_clr bit pulses in the same cycle as call_req.
- R7: External sources (index 0 and index 2) get a flag_clr pulse when chosen only if their edge_mode bit was 1 at the poll. With edge_mode 0 their flag_clr bit stays 0.
- R8: Sources other than 0–3 (serial, watchdog and the rest) never receive a flag_clr pulse.
- R9: svc_level bit 1 marks a high-level routine in service, and bit 0 marks a low-level one. A high-level request is accepted only while bit 1 is 0. A low-level request is accepted only while both bits are 0.
- R10: A reti_stb pulse clears the highest set svc_level bit. A ret_stb pulse leaves svc_level unchanged.
- R11: Slots 12 to 15 are unused and are never chosen, even when their flag inputs are driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Machine-cycle poll strobe |
| cpu_ready | input | 1 | Core can accept a hardware call |
| glb_en | input | 1 | Global interrupt enable |
| irq_flag | input | 16 | Per-source request flags |
| irq_en | input | 16 | Per-source enables |
| irq_hi | input | 16 | Per-source high-priority select |
| edge_mode | input | 16 | Edge (1) or level (0) mode, used for external sources |
| reti_stb | input | 1 | Return-from-interrupt executed |
| ret_stb | input | 1 | Plain return executed |
| call_req | output | 1 | One-cycle hardware-call request |
| vec_addr | output | 16 | Vector address of the chosen source |
| flag_clr | output | 16 | One-cycle hardware clear strobes |
| svc_level | output | 2 | In-service levels {high, low} |

## Verification
A poll and a return-from-interrupt can land on the same edge. The bench forces this by raising reti_stb together with cyc_stb while a low-level routine is in service and a high-level flag is pending. It expects no call in the next cycle and expects the low in-service bit to clear. A second case is a vector issued in the same cycle as a hardware clear: each table row checks the vector, the call pulse and the exact clear mask together.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;

   function automatic logic [15:0] vec_of(input int unsigned idx,
                                          input int unsigned base,
                                          input int unsigned stride);
      return 16'(base + stride * idx);
   endfunction

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
   parameter bit TWO_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take_hi,
   input  logic take_lo,
   input  logic reti,
   output logic busy_hi,
   output logic busy_lo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_lo <= 1'b0;
      end else if (take_lo) begin
         busy_lo <= 1'b1;
      end else if (reti && !busy_hi) begin
         busy_lo <= 1'b0;
      end
   end

   generate
      if (TWO_LEVEL) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_hi <= 1'b0;
            end else if (take_hi) begin
               busy_hi <= 1'b1;
            end else if (reti) begin
               busy_hi <= 1'b0;
            end
         end
      end else begin : g_one
         assign busy_hi = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out #(
   parameter int N          = 16,
   parameter int IW         = 4,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [IW-1:0] sel_idx,
   input  logic [N-1:0]  clr_ok,
   output logic          call_req,
   output logic [15:0]   vec_addr,
   output logic [N-1:0]  flag_clr
);
   import irq_poll_pkg::*;

   logic [N-1:0] sel_hot;

   always_comb begin
      sel_hot = '0;
      sel_hot[sel_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         call_req <= 1'b0;
         vec_addr <= 16'(VEC_BASE);
         flag_clr <= '0;
      end else begin
         call_req <= take;
         flag_clr <= take ? (sel_hot & clr_ok) : '0;
         if (take) begin
            vec_addr <= vec_of(int'(sel_idx), VEC_BASE, VEC_STRIDE);
         end
      end
   end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl #(
   parameter int           NSRC       = 16,
   parameter int           VEC_BASE   = 3,
   parameter int           VEC_STRIDE = 8,
   parameter bit           TWO_LEVEL  = 1'b1,
   parameter logic [NSRC-1:0] TIMER_MASK = 16'h000A,
   parameter logic [NSRC-1:0] EXT_MASK   = 16'h0005,
   parameter logic [NSRC-1:0] SLOT_USED  = 16'h0FFF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_stb,
   input  logic            cpu_ready,
   input  logic            glb_en,
   input  logic [NSRC-1:0] irq_flag,
   input  logic [NSRC-1:0] irq_en,
   input  logic [NSRC-1:0] irq_hi,
   input  logic [NSRC-1:0] edge_mode,
   input  logic            reti_stb,
   input  logic            ret_stb,
   output logic            call_req,
   output logic [15:0]     vec_addr,
   output logic [NSRC-1:0] flag_clr,
   output logic [1:0]      svc_level
);
   import irq_poll_pkg::*;

   localparam int IW = idx_bits(NSRC);

   if (NSRC < 1 || NSRC > 16) begin : g_bad_n
      $error("irq_poll_ctrl: NSRC must be 1..16");
   end
   if (VEC_BASE + VEC_STRIDE * (NSRC - 1) > 16'hFFFF) begin : g_bad_vec
      $error("irq_poll_ctrl: vector range exceeds 16 bits");
   end
   if ((TIMER_MASK & EXT_MASK) != '0) begin : g_bad_mask
      $error("irq_poll_ctrl: a source cannot be both timer and external");
   end

   logic [NSRC-1:0] live, hi_eff, req_hi, req_lo, clr_ok;
   logic            hi_found, lo_found, poll_ok, take_hi, take_lo, take;
   logic            busy_hi, busy_lo;
   logic [IW-1:0]   hi_idx, lo_idx, sel_idx;
   logic            ret_unused;

   assign ret_unused = ret_stb;

   generate
      if (TWO_LEVEL) begin : g_lvl2
         assign hi_eff = irq_hi;
      end else begin : g_lvl1
         assign hi_eff = '0;
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_clr
         assign clr_ok[i] = TIMER_MASK[i] | (EXT_MASK[i] & edge_mode[i]);
      end
   endgenerate

   assign live   = irq_flag & irq_en & SLOT_USED;
   assign req_hi = live & hi_eff;
   assign req_lo = live & ~hi_eff;

   irq_first_set #(.N(NSRC), .IW(IW)) u_pick_hi (
      .req(req_hi), .found(hi_found), .idx(hi_idx));
   irq_first_set #(.N(NSRC), .IW(IW)) u_pick_lo (
      .req(req_lo), .found(lo_found), .idx(lo_idx));

   assign poll_ok = cyc_stb & cpu_ready & glb_en & ~reti_stb;
   assign take_hi = poll_ok & hi_found & ~busy_hi;
   assign take_lo = poll_ok & lo_found & ~hi_found & ~busy_hi & ~busy_lo;
   assign take    = take_hi | take_lo;
   assign sel_idx = take_hi ? hi_idx : lo_idx;

   irq_svc_track #(.TWO_LEVEL(TWO_LEVEL)) u_svc (
      .clk(clk), .rst_n(rst_n), .take_hi(take_hi), .take_lo(take_lo),
      .reti(reti_stb), .busy_hi(busy_hi), .busy_lo(busy_lo));

   irq_vec_out #(.N(NSRC), .IW(IW), .VEC_BASE(VEC_BASE),
                 .VEC_STRIDE(VEC_STRIDE)) u_out (
      .clk(clk), .rst_n(rst_n), .take(take), .sel_idx(sel_idx),
      .clr_ok(clr_ok), .call_req(call_req), .vec_addr(vec_addr),
      .flag_clr(flag_clr));

   assign svc_level = {busy_hi, busy_lo};
endmodule

// File: rtl/irq_poll_ctrl_chk.sv
module irq_poll_ctrl_chk #(
   parameter int              NSRC       = 16,
   parameter int              VEC_BASE   = 3,
   parameter int              VEC_STRIDE = 8,
   parameter logic [NSRC-1:0] TIMER_MASK = 16'h000A,
   parameter logic [NSRC-1:0] EXT_MASK   = 16'h0005,
   parameter logic [NSRC-1:0] SLOT_USED  = 16'h0FFF
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cyc_stb,
   input logic            cpu_ready,
   input logic            glb_en,
   input logic [NSRC-1:0] irq_flag,
   input logic [NSRC-1:0] irq_en,
   input logic [NSRC-1:0] edge_mode,
   input logic            reti_stb,
   input logic            call_req,
   input logic [15:0]     vec_addr,
   input logic [NSRC-1:0] flag_clr,
   input logic [1:0]      svc_level
);
   logic [NSRC-1:0] live_q, edge_q;
   logic [1:0]      svc_q;
   logic            cond_q, reti_q;
   int unsigned     ci;
   logic [15:0]     off;

   assign off = vec_addr - 16'(VEC_BASE);
   assign ci  = int'(off) / VEC_STRIDE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0; edge_q <= '0; svc_q <= '0; cond_q <= 1'b0; reti_q <= 1'b0;
      end else begin
         live_q <= irq_flag & irq_en;
         edge_q <= edge_mode;
         svc_q  <= svc_level;
         cond_q <= cyc_stb & cpu_ready & glb_en & ~reti_stb;
         reti_q <= reti_stb;
      end
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!call_req && flag_clr == '0 && svc_level == 2'b00));
   a_r2_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> ((int'(off) % VEC_STRIDE) == 0 && ci < NSRC));
   a_r3_poll_gate: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> cond_q);
   a_r4_live_at_poll: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> ((live_q >> ci) & 1) == 1);
   a_r6_clr_with_call: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr != '0) |-> (call_req && $onehot0(flag_clr) && ((flag_clr >> ci) & 1) == 1));
   a_r6_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && ((TIMER_MASK >> ci) & 1) == 1) |-> ((flag_clr >> ci) & 1) == 1);
   a_r7_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr & EXT_MASK & ~edge_q) == '0);
   a_r8_sw_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr & ~(TIMER_MASK | EXT_MASK)) == '0);
   a_r9_nest_order: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> !svc_q[1]);
   a_r10_reti_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((svc_q & ~svc_level) != 2'b00) |-> reti_q);
   a_r11_unused_slot: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> ((SLOT_USED >> ci) & 1) == 1);
endmodule

bind irq_poll_ctrl irq_poll_ctrl_chk #(
   .NSRC(NSRC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
   .TIMER_MASK(TIMER_MASK), .EXT_MASK(EXT_MASK), .SLOT_USED(SLOT_USED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cpu_ready(cpu_ready),
   .glb_en(glb_en), .irq_flag(irq_flag), .irq_en(irq_en),
   .edge_mode(edge_mode), .reti_stb(reti_stb), .call_req(call_req),
   .vec_addr(vec_addr), .flag_clr(flag_clr), .svc_level(svc_level));

// File: tb/irq_poll_ctrl_bench.sv
module irq_poll_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_stb = 1'b0, cpu_ready = 1'b0, glb_en = 1'b0;
   logic [15:0] irq_flag = '0, irq_en = '0, irq_hi = '0, edge_mode = '0;
   logic        reti_stb = 1'b0, ret_stb = 1'b0;
   logic        call_req;
   logic [15:0] vec_addr, flag_clr;
   logic [1:0]  svc_level;
   int          total = 0, fails = 0;

   always #4 clk = ~clk;

   irq_poll_ctrl u_irq_poll_ctrl (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cpu_ready(cpu_ready),
      .glb_en(glb_en), .irq_flag(irq_flag), .irq_en(irq_en), .irq_hi(irq_hi),
      .edge_mode(edge_mode), .reti_stb(reti_stb), .ret_stb(ret_stb),
      .call_req(call_req), .vec_addr(vec_addr), .flag_clr(flag_clr),
      .svc_level(svc_level));

   typedef struct packed {
      logic [15:0] flag, en, hi, edg;
      logic        glb, rdy, call;
      logic [3:0]  idx;
      logic [15:0] clr;
      logic [3:0]  req;
   } row_t;

   localparam int NROW = 15;
   localparam row_t TBL [NROW] = '{
      '{16'h0002, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd1,  16'h0002, 4'd6},
      '{16'h0008, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd3,  16'h0008, 4'd6},
      '{16'h0001, 16'hFFFF, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1, 4'd0,  16'h0001, 4'd7},
      '{16'h0001, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd0,  16'h0000, 4'd7},
      '{16'h0004, 16'hFFFF, 16'h0000, 16'h0004, 1'b1, 1'b1, 1'b1, 4'd2,  16'h0004, 4'd7},
      '{16'h0010, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 4'd4,  16'h0000, 4'd8},
      '{16'h0800, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 4'd11, 16'h0000, 4'd8},
      '{16'h0018, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd3,  16'h0008, 4'd5},
      '{16'h0012, 16'hFFFF, 16'h0010, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd4,  16'h0000, 4'd5},
      '{16'h0006, 16'h0004, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd2,  16'h0000, 4'd4},
      '{16'h0002, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000, 4'd3},
      '{16'h0002, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0000, 4'd3},
      '{16'hF000, 16'hFFFF, 16'hF000, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd0,  16'h0000, 4'd11},
      '{16'hF020, 16'hFFFF, 16'hF000, 16'h0000, 1'b1, 1'b1, 1'b1, 4'd5,  16'h0000, 4'd11},
      '{16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd0,  16'h0000, 4'd4}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Poll on one edge; outputs sampled at the following negedge.
   task automatic do_poll(input logic with_reti);
      @(negedge clk);
      cyc_stb  = 1'b1;
      reti_stb = with_reti;
      @(negedge clk);
      cyc_stb  = 1'b0;
      reti_stb = 1'b0;
   endtask

   task automatic do_reti();
      @(negedge clk); reti_stb = 1'b1;
      @(negedge clk); reti_stb = 1'b0;
   endtask

   function automatic logic [15:0] exp_vec(input int idx);
      return 16'h0003 + 16'(8 * idx);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", total, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 call in reset", 32'(call_req), 0);
      chk("R1 clr in reset", 32'(flag_clr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 svc after reset", 32'(svc_level), 0);
      chk("R1 call after reset", 32'(call_req), 0);

      for (int r = 0; r < NROW; r++) begin
         string tag;
         tag = $sformatf("R%0d row%0d", TBL[r].req, r);
         irq_flag = TBL[r].flag; irq_en = TBL[r].en; irq_hi = TBL[r].hi;
         edge_mode = TBL[r].edg; glb_en = TBL[r].glb; cpu_ready = TBL[r].rdy;
         do_poll(1'b0);
         chk({tag, " call"}, 32'(call_req), 32'(TBL[r].call));
         chk({tag, " clr"}, 32'(flag_clr), 32'(TBL[r].clr));
         if (TBL[r].call) begin
            chk({tag, " R2 vec"}, 32'(vec_addr), 32'(exp_vec(int'(TBL[r].idx))));
            irq_flag = '0;
            do_reti();
            chk({tag, " R10 svc back"}, 32'(svc_level), 0);
         end
         irq_flag = '0;
      end

      // R3: no poll strobe, no call
      irq_en = '1; irq_hi = '0; edge_mode = '0; glb_en = 1'b1; cpu_ready = 1'b1;
      irq_flag = 16'h0002;
      @(negedge clk); @(negedge clk);
      chk("R3 no cyc_stb", 32'(call_req), 0);

      // R4: flag seen while refused, gone when accepted
      cpu_ready = 1'b0;
      do_poll(1'b0);
      chk("R4 refused poll", 32'(call_req), 0);
      irq_flag = '0; cpu_ready = 1'b1;
      do_poll(1'b0);
      chk("R4 not remembered", 32'(call_req), 0);

      // R9: low accepted, then nesting rules
      irq_flag = 16'h0010;
      do_poll(1'b0);
      chk("R9 low taken", 32'(call_req), 1);
      chk("R9 svc low", 32'(svc_level), 32'h1);
      irq_flag = 16'h0002;
      do_poll(1'b0);
      chk("R9 low blocked by low", 32'(call_req), 0);
      irq_flag = 16'h0040; irq_hi = 16'h0041;
      do_poll(1'b0);
      chk("R9 high nests", 32'(call_req), 1);
      chk("R9 high vec", 32'(vec_addr), 32'(exp_vec(6)));
      chk("R9 svc both", 32'(svc_level), 32'h3);
      irq_flag = 16'h0001;
      do_poll(1'b0);
      chk("R9 high blocked by high", 32'(call_req), 0);

      // R10: plain return keeps, reti peels high then low
      irq_flag = '0;
      @(negedge clk); ret_stb = 1'b1;
      @(negedge clk); ret_stb = 1'b0;
      chk("R10 ret ignored", 32'(svc_level), 32'h3);
      do_reti();
      chk("R10 reti clears high", 32'(svc_level), 32'h1);

      // R3: poll coinciding with reti is refused, reti still applied
      irq_flag = 16'h0040;
      do_poll(1'b1);
      chk("R3 poll with reti", 32'(call_req), 0);
      chk("R10 reti same edge", 32'(svc_level), 32'h0);
      do_poll(1'b0);
      chk("R5 high after release", 32'(vec_addr), 32'(exp_vec(6)));
      irq_flag = '0;
      do_reti();

      $display("== %0d vectors applied, %0d miscompares ==", total, fails);
      $finish;
   end
endmodule